// File: doc/BRIEF.md
# Vector Mask Scan Unit

This unit takes a packed bit mask of up to `N` elements and a runtime active length `vl`. When `start` is pulsed, it computes four results from the active part of the mask. The results are the index of the lowest set element, the index of the highest set element, the number of set elements, and an exclusive running count for every element position. Elements at or above `vl` are cleared before any of this work, so stale contents in the upper mask bits never reach a result.

A two-bit operation code, captured together with `start`, chooses which of the three scalar results drives `result_scalar`. The scalar is signed and `XLEN` bits wide, and an empty search returns all ones (-1). The running-count vector is always presented on `prefix_vec`. Every output is a register. `done` pulses for one cycle, in the cycle after `start`, and the outputs then hold until the next `start`. A vector pipeline uses the unit for loop-exit tests (first set lane), for last-lane extraction, and for compaction offsets (the running counts).

Top module: `mscan_unit`

## Requirements
- R1: With `op` = 0, `result_scalar` is the index of the lowest-numbered set active element, zero-extended to `XLEN` bits. If no active element is set, it is all ones (-1).
- R2: With `op` = 1, `result_scalar` is the index of the highest-numbered set active element. If no active element is set, it is all ones (-1).
- R3: With `op` = 2, `result_scalar` is the count of set active elements.
- R4: `prefix_vec[i*SEW +: SEW]` holds the number of set active elements at positions strictly below `i`. Element 0 is therefore always 0.
- R5: Mask bits at positions >= `vl` do not affect any result. A `vl` larger than `N` behaves as `vl` = `N`. With `vl` = 0, both find results are -1, the count is 0 and the prefix vector is all zero.
- R6: With `op` = 3, `result_scalar` is 0.
- R7: `done` is high in exactly the cycle after a cycle with `start` high, and low otherwise. With no `start`, `result_scalar` and `prefix_vec` keep their values even when the inputs change.
- R8: For `vl` > 0, the prefix element of the last active position plus that position's mask bit equals the count.
- R9: After synchronous reset, `done`, `result_scalar` and `prefix_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture inputs and compute results |
| mask | input | N | Packed element mask, element i at bit i |
| vl | input | $clog2(N+1) | Active element count |
| op | input | 2 | Scalar select: 0 first, 1 last, 2 count, 3 zero |
| done | output | 1 | One-cycle pulse, results valid |
| result_scalar | output | XLEN | Selected scalar result, signed |
| prefix_vec | output | N*SEW | Exclusive running counts, SEW bits per element |

## Verification
The assertions assume `start` is never held through reset. They also assume `SEW` and `XLEN` are wide enough to hold `N` without wrapping, so a count and an index compare exactly. The bench sweeps a small configuration with `N` = 8, `SEW` = 4 and `XLEN` = 16, which keeps both widths clear of overflow. The sweep covers every mask value, every `vl` from 0 to 15 (including values beyond `N`) and every operation code. Because every mask value appears, every `vl` is tried with set bits above it. `start` is driven for single cycles only, with reset released beforehand.

// File: rtl/mscan_pkg.sv
package mscan_pkg;

  typedef enum logic [1:0] {
    MS_OP_FIRST = 2'd0,
    MS_OP_LAST  = 2'd1,
    MS_OP_COUNT = 2'd2,
    MS_OP_NONE  = 2'd3
  } ms_op_e;

endpackage

// File: rtl/mscan_trim.sv
// Clears every mask element at or above the active length.
module mscan_trim #(
  parameter int N   = 64,
  parameter int VLW = $clog2(N + 1)
) (
  input  logic [N-1:0]   mask_i,
  input  logic [VLW-1:0] vl_i,
  output logic [N-1:0]   mask_o
);

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam logic [VLW-1:0] LANE = VLW'(i);
    assign mask_o[i] = mask_i[i] & (vl_i > LANE);
  end

endmodule

// File: rtl/mscan_prefix.sv
// Ripple chain of exclusive running counts plus the total.
module mscan_prefix #(
  parameter int N   = 64,
  parameter int SEW = 8,
  parameter int CW  = $clog2(N + 1)
) (
  input  logic [N-1:0]     mask_i,
  output logic [N*SEW-1:0] prefix_o,
  output logic [CW-1:0]    count_o
);

  logic [CW-1:0] run [N+1];

  assign run[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign run[i+1] = run[i] + CW'(mask_i[i]);
    if (SEW >= CW) begin : g_wide
      assign prefix_o[i*SEW +: SEW] = SEW'(run[i]);
    end else begin : g_narrow
      assign prefix_o[i*SEW +: SEW] = run[i][SEW-1:0];
    end
  end

  assign count_o = run[N];

endmodule

// File: rtl/mscan_find.sv
// Lowest and highest set element search.
module mscan_find #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic [IW-1:0] first_o,
  output logic [IW-1:0] last_o,
  output logic          any_o
);

  always_comb begin
    first_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) first_o = IW'(i);
    end
  end

  always_comb begin
    last_o = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i]) last_o = IW'(i);
    end
  end

  assign any_o = |mask_i;

endmodule

// File: rtl/mscan_unit.sv
module mscan_unit
  import mscan_pkg::*;
#(
  parameter int N    = 64,
  parameter int SEW  = 8,
  parameter int XLEN = 64,
  localparam int VLW = $clog2(N + 1),
  localparam int CW  = $clog2(N + 1),
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N-1:0]      mask,
  input  logic [VLW-1:0]    vl,
  input  logic [1:0]        op,
  output logic              done,
  output logic [XLEN-1:0]   result_scalar,
  output logic [N*SEW-1:0]  prefix_vec
);

  logic [N-1:0]     mask_t;
  logic [N*SEW-1:0] prefix_c;
  logic [CW-1:0]    count_c;
  logic [IW-1:0]    first_c;
  logic [IW-1:0]    last_c;
  logic             any_c;
  logic [XLEN-1:0]  scalar_c;
  ms_op_e           op_e;

  mscan_trim #(.N(N), .VLW(VLW)) u_trim (
    .mask_i (mask),
    .vl_i   (vl),
    .mask_o (mask_t)
  );

  mscan_prefix #(.N(N), .SEW(SEW), .CW(CW)) u_prefix (
    .mask_i   (mask_t),
    .prefix_o (prefix_c),
    .count_o  (count_c)
  );

  mscan_find #(.N(N), .IW(IW)) u_find (
    .mask_i  (mask_t),
    .first_o (first_c),
    .last_o  (last_c),
    .any_o   (any_c)
  );

  assign op_e = ms_op_e'(op);

  always_comb begin
    unique case (op_e)
      MS_OP_FIRST: scalar_c = any_c ? XLEN'(first_c) : '1;
      MS_OP_LAST:  scalar_c = any_c ? XLEN'(last_c)  : '1;
      MS_OP_COUNT: scalar_c = XLEN'(count_c);
      default:     scalar_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done          <= 1'b0;
      result_scalar <= '0;
      prefix_vec    <= '0;
    end else begin
      done <= start;
      if (start) begin
        result_scalar <= scalar_c;
        prefix_vec    <= prefix_c;
      end
    end
  end

  // Running count at the last active lane, for the end-of-chain invariant.
  logic [SEW-1:0] tail_sum;
  logic           tail_ok;
  always_comb begin
    tail_sum = '0;
    tail_ok  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if ((int'(vl) == i + 1) || ((i == N - 1) && (int'(vl) > N))) begin
        tail_sum = prefix_c[i*SEW +: SEW] + SEW'(mask_t[i]);
        tail_ok  = 1'b1;
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> done);  // R7
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));  // R7
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(result_scalar) && $stable(prefix_vec)));  // R7
  AST_PREFIX_BASE_ZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> (prefix_vec[SEW-1:0] == '0));  // R4
  AST_EMPTY_AGREES: assert property (@(posedge clk) disable iff (rst)
    start |-> ((count_c == '0) == !any_c));  // R1
  AST_LAST_NOT_BELOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    (start && any_c) |-> (last_c >= first_c));  // R2
  AST_TAIL_INVARIANT: assert property (@(posedge clk) disable iff (rst)
    (start && tail_ok) |-> (tail_sum == SEW'(count_c)));  // R8
  AST_ZERO_VL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (start && vl == '0) |-> (!any_c && count_c == '0));  // R5

endmodule

// File: tb/mscan_unit_bench.sv
`timescale 1ns/1ps
module mscan_unit_bench;

  localparam int N    = 8;
  localparam int SEW  = 4;
  localparam int XLEN = 16;
  localparam int VLW  = $clog2(N + 1);

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic [N-1:0]      mask;
  logic [VLW-1:0]    vl;
  logic [1:0]        op;
  logic              done;
  logic [XLEN-1:0]   result_scalar;
  logic [N*SEW-1:0]  prefix_vec;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mscan_unit #(.N(N), .SEW(SEW), .XLEN(XLEN)) u_mscan_unit (
    .clk(clk), .rst(rst), .start(start), .mask(mask), .vl(vl), .op(op),
    .done(done), .result_scalar(result_scalar), .prefix_vec(prefix_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int eff_vl(input int v);
    return (v > N) ? N : v;
  endfunction

  function automatic int ref_first(input int m, input int v);
    for (int i = 0; i < eff_vl(v); i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int ref_last(input int m, input int v);
    for (int i = eff_vl(v) - 1; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int ref_prefix(input int m, input int v, input int k);
    int c = 0;
    for (int i = 0; i < k && i < eff_vl(v); i++) c += m[i];
    return c;
  endfunction

  task automatic run(input int m, input int v, input int o);
    int exp;
    int tail;
    @(negedge clk);
    mask  = N'(m);
    vl    = VLW'(v);
    op    = 2'(o);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done", int'(done), 1);
    case (o)
      0: exp = ref_first(m, v);
      1: exp = ref_last(m, v);
      2: exp = ref_prefix(m, v, N);
      default: exp = 0;
    endcase
    case (o)
      0: chk("R1/R5 first", int'(result_scalar), exp & 16'hFFFF);
      1: chk("R2/R5 last", int'(result_scalar), exp & 16'hFFFF);
      2: chk("R3/R5 count", int'(result_scalar), exp);
      default: chk("R6 zero", int'(result_scalar), 0);
    endcase
    for (int k = 0; k < N; k++)
      chk("R4/R5 prefix", int'(prefix_vec[k*SEW +: SEW]), ref_prefix(m, v, k));
    if (o == 2 && eff_vl(v) > 0) begin
      tail = int'(prefix_vec[(eff_vl(v)-1)*SEW +: SEW]) + m[eff_vl(v)-1];
      chk("R8 tail invariant", tail, int'(result_scalar));
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [XLEN-1:0]  held_s;
    logic [N*SEW-1:0] held_p;
    rst = 1'b1; start = 1'b0; mask = '0; vl = '0; op = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 done", int'(done), 0);
    chk("R9 scalar", int'(result_scalar), 0);
    chk("R9 prefix", int'(prefix_vec == '0), 1);

    // Full sweep: every mask, vl 0..15 (beyond N too), every op.
    for (int v = 0; v < 16; v++)
      for (int m = 0; m < 256; m++)
        for (int o = 0; o < 4; o++)
          run(m, v, o);

    // Hold: outputs keep their values while inputs change without start.
    run(8'b0111_0100, 8, 1);
    chk("R2 example", int'(result_scalar), 6);
    held_s = result_scalar;
    held_p = prefix_vec;
    mask = 8'hFF; vl = 4'd3; op = 2'd2;
    @(negedge clk);
    chk("R7 done low", int'(done), 0);
    @(negedge clk);
    chk("R7 scalar hold", int'(result_scalar), int'(held_s));
    chk("R7 prefix hold", int'(prefix_vec == held_p), 1);

    // Stated example: 0000_0110 gives counts 2,2,2,2,2,1,0,0 for elements 7..0.
    run(8'b0000_0110, 8, 2);
    chk("R4 example e2", int'(prefix_vec[2*SEW +: SEW]), 1);
    chk("R4 example e7", int'(prefix_vec[7*SEW +: SEW]), 2);
    report();
  end

endmodule